// File: doc/BRIEF.md
# Highway and Farm Road Signal Controller

This block sequences the lamps at a crossing where a busy highway meets a farm road that carries little traffic. The highway keeps its green until a car is waiting on the farm road and the long interval has run out. The signal then gives the highway a yellow, then a green to the farm road. The farm road keeps its green only while a car is still waiting, and never beyond the long interval. It then gets a yellow, and the highway gets its green again.

The interval timer sits outside the block. The controller sends it a one-cycle start strobe on every phase change, and again when reset is applied. The timer answers with two expiry pulses. The short pulse times the yellows and the long pulse times the greens. Lamp outputs are decoded from the registered phase, so they never glitch when the inputs change within a cycle.

Top module: `sig_ctl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) puts the block in the highway-green phase (hwy_lamp = 3'b001, farm_lamp = 3'b100) and drives start_tmr to 1 for as long as reset is held.
- R2: In the highway-green phase the block moves to highway-yellow (hwy_lamp = 3'b010) only when car_waiting and long_done are both 1 at a clock edge. Otherwise it stays in highway-green, and short_done has no effect there.
- R3: In the highway-yellow phase a short_done pulse moves the block to farm-green (farm_lamp = 3'b001, hwy_lamp = 3'b100). Without it the block stays in yellow, whatever car_waiting and long_done are.
- R4: In the farm-green phase the block moves to farm-yellow (farm_lamp = 3'b010) when long_done is 1 or car_waiting is 0. While car_waiting is 1 and long_done is 0 it stays in farm-green.
- R5: In the farm-yellow phase a short_done pulse returns the block to highway-green. Without it the block stays in farm-yellow, whatever car_waiting and long_done are.
- R6: Outside reset, start_tmr is 1 in exactly the cycles that directly follow a clock edge at which the phase changed, and 0 otherwise.
- R7: Each lamp vector is one-hot (bit 0 green, bit 1 yellow, bit 2 red), and at least one of the two roads shows red in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| car_waiting | input | 1 | A car is detected on the farm road |
| short_done | input | 1 | Short interval has expired (times yellows) |
| long_done | input | 1 | Long interval has expired (times greens) |
| hwy_lamp | output | 3 | Highway lamps: bit 0 green, bit 1 yellow, bit 2 red |
| farm_lamp | output | 3 | Farm road lamps: bit 0 green, bit 1 yellow, bit 2 red |
| start_tmr | output | 1 | One-cycle strobe that restarts the external interval timer |

## Verification
The hardest case to reach is two phase changes on consecutive edges, which makes start_tmr stay high for two cycles in a row. This happens when short_done arrives in the very first cycle of a yellow. A real timer would never do that, but the bench plays the timer's part and can drive the expiry pulses in any cycle. For each of the four phases it walks the block there along a known path and applies all eight input combinations. It then runs a long pseudo-random walk checked against a bench-side model of the phase rules, and finally applies reset from the farm-green phase.

// File: rtl/sig_ctl_pkg.sv
// Package: shared phase encoding and lamp codes for the crossing controller.
// Assumes lamp vectors are ordered {red, yellow, green}.
package sig_ctl_pkg;

    localparam int LAMP_W = 3;

    typedef enum logic [1:0] {
        PH_HWY_GO   = 2'd0,
        PH_HWY_WARN = 2'd1,
        PH_FARM_GO  = 2'd2,
        PH_FARM_WARN = 2'd3
    } phase_e;

    localparam logic [LAMP_W-1:0] LAMP_GREEN  = 3'b001;
    localparam logic [LAMP_W-1:0] LAMP_YELLOW = 3'b010;
    localparam logic [LAMP_W-1:0] LAMP_RED    = 3'b100;

endpackage

// File: rtl/sig_ctl_next.sv
// Module: combinational phase-advance rules.
// Greens are bounded by long_done and yellows by short_done. The farm green
// also ends as soon as no car is sensed. Assumes inputs are synchronous to clk.
module sig_ctl_next
    import sig_ctl_pkg::*;
(
    input  phase_e cur,
    input  logic   car,
    input  logic   short_exp,
    input  logic   long_exp,
    output phase_e nxt,
    output logic   advance
);

    // Pick the following phase from the current one and the inputs.
    always_comb begin
        nxt = cur;
        case (cur)
            PH_HWY_GO:    if (long_exp && car)  nxt = PH_HWY_WARN;
            PH_HWY_WARN:  if (short_exp)        nxt = PH_FARM_GO;
            PH_FARM_GO:   if (long_exp || !car) nxt = PH_FARM_WARN;
            PH_FARM_WARN: if (short_exp)        nxt = PH_HWY_GO;
            default:                            nxt = PH_HWY_GO;
        endcase
    end

    // Flag a phase change so the timer can be restarted.
    always_comb advance = (nxt != cur);

endmodule

// File: rtl/sig_ctl_lamps.sv
// Module: lamp decoder for both roads.
// Assumes the phase input comes straight from a register, which keeps the
// lamp outputs free of glitches.
module sig_ctl_lamps
    import sig_ctl_pkg::*;
(
    input  phase_e            ph,
    output logic [LAMP_W-1:0] hwy,
    output logic [LAMP_W-1:0] farm
);

    // Map each phase to one lamp per road.
    always_comb begin
        hwy  = LAMP_RED;
        farm = LAMP_RED;
        case (ph)
            PH_HWY_GO:    hwy  = LAMP_GREEN;
            PH_HWY_WARN:  hwy  = LAMP_YELLOW;
            PH_FARM_GO:   farm = LAMP_GREEN;
            PH_FARM_WARN: farm = LAMP_YELLOW;
            default:      hwy  = LAMP_RED;
        endcase
    end

endmodule

// File: rtl/sig_ctl.sv
// Module: top of the crossing signal controller.
// Holds the registered phase and the timer start strobe. Assumes an external
// interval timer restarts on start_tmr and later pulses short_done/long_done.
module sig_ctl
    import sig_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              car_waiting,
    input  logic              short_done,
    input  logic              long_done,
    output logic [LAMP_W-1:0] hwy_lamp,
    output logic [LAMP_W-1:0] farm_lamp,
    output logic              start_tmr
);

    phase_e phase_q;
    phase_e phase_d;
    logic   advance;

    sig_ctl_next u_next (
        .cur       (phase_q),
        .car       (car_waiting),
        .short_exp (short_done),
        .long_exp  (long_done),
        .nxt       (phase_d),
        .advance   (advance)
    );

    sig_ctl_lamps u_lamps (
        .ph   (phase_q),
        .hwy  (hwy_lamp),
        .farm (farm_lamp)
    );

    // Phase register, cleared to highway green by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_HWY_GO;
        else        phase_q <= phase_d;
    end

    // Timer strobe: held high during reset, else high after each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) start_tmr <= 1'b1;
        else        start_tmr <= advance;
    end

    // R7: one lamp per road, and at least one road red.
    p_lamps_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1)
        && (hwy_lamp[2] || farm_lamp[2]));

    // R2: the highway green holds unless a car waits and the long interval is over.
    p_hwy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp == LAMP_GREEN && !(car_waiting && long_done)) |=> (hwy_lamp == LAMP_GREEN));

    // R3: the short pulse in highway yellow hands the green to the farm road.
    p_hwy_yellow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_lamp == LAMP_YELLOW && short_done) |=> (farm_lamp == LAMP_GREEN));

    // R4: the farm green ends on the long pulse or when no car is sensed.
    p_farm_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_lamp == LAMP_GREEN && (long_done || !car_waiting)) |=> (farm_lamp == LAMP_YELLOW));

    // R5: the short pulse in farm yellow gives the green back to the highway.
    p_farm_yellow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (farm_lamp == LAMP_YELLOW && short_done) |=> (hwy_lamp == LAMP_GREEN));

    // R6: any change of the lamps comes with a timer strobe.
    p_strobe_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((hwy_lamp != $past(hwy_lamp)) || (farm_lamp != $past(farm_lamp))))
        |-> start_tmr);

    // R6: a strobe after reset is released only comes with a lamp change.
    p_strobe_only_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && start_tmr)
        |-> ((hwy_lamp != $past(hwy_lamp)) || (farm_lamp != $past(farm_lamp))));

    // R1: the reset state is highway green with the strobe raised.
    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (hwy_lamp == LAMP_GREEN && farm_lamp == LAMP_RED && start_tmr));

endmodule

// File: tb/test_sig_ctl.sv
module test_sig_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car = 1'b0;
    logic       sdone = 1'b0;
    logic       ldone = 1'b0;
    logic [2:0] hwy;
    logic [2:0] farm;
    logic       strt;

    int n_tests = 0;
    int n_fail  = 0;
    int model_ph = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    sig_ctl i_sig_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .car_waiting(car),
        .short_done (sdone),
        .long_done  (ldone),
        .hwy_lamp   (hwy),
        .farm_lamp  (farm),
        .start_tmr  (strt)
    );

    function automatic logic [2:0] exp_hwy(int ph);
        return (ph == 0) ? 3'b001 : (ph == 1) ? 3'b010 : 3'b100;
    endfunction

    function automatic logic [2:0] exp_farm(int ph);
        return (ph == 2) ? 3'b001 : (ph == 3) ? 3'b010 : 3'b100;
    endfunction

    function automatic int model_next(int ph, logic c, logic s, logic l);
        case (ph)
            0: return (c && l) ? 1 : 0;
            1: return s ? 2 : 1;
            2: return (l || !c) ? 3 : 2;
            default: return s ? 0 : 3;
        endcase
    endfunction

    task automatic check(string tag, logic [6:0] got, logic [6:0] want);
        n_tests++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: got hwy/farm/st=%b expected %b", tag, got, want);
        end
    endtask

    function automatic string tag_of(int ph);
        case (ph)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One clock with given inputs; compare with the model after the edge.
    task automatic step(logic c, logic s, logic l);
        int nx;
        @(negedge clk);
        car = c; sdone = s; ldone = l;
        nx = model_next(model_ph, c, s, l);
        @(posedge clk);
        #2;
        check(tag_of(model_ph), {hwy, farm, strt},
              {exp_hwy(nx), exp_farm(nx), logic'(nx != model_ph)});
        if (strt !== logic'(nx != model_ph))
            check("R6", {6'b0, strt}, {6'b0, logic'(nx != model_ph)});
        check("R7", {4'b0, hwy[2] | farm[2], logic'($countones(hwy) == 1),
                     logic'($countones(farm) == 1)}, 7'b0000111);
        model_ph = nx;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; car = 1'b0; sdone = 1'b0; ldone = 1'b0;
        @(posedge clk); #2;
        check("R1", {hwy, farm, strt}, {3'b001, 3'b100, 1'b1});
        @(posedge clk); #2;
        check("R1", {hwy, farm, strt}, {3'b001, 3'b100, 1'b1});
        @(negedge clk);
        rst_n = 1'b1;
        model_ph = 0;
    endtask

    task automatic go_to(int ph);
        if (ph >= 1) step(1'b1, 1'b0, 1'b1);
        if (ph >= 2) step(1'b0, 1'b1, 1'b0);
        if (ph >= 3) step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: first cycle out of reset with idle inputs stays put, strobe drops.
        step(1'b0, 1'b0, 1'b0);

        // Exhaustive sweep: every phase under every input combination.
        for (int ph = 0; ph < 4; ph++) begin
            for (int v = 0; v < 8; v++) begin
                do_reset();
                go_to(ph);
                step(v[2], v[1], v[0]);
                step(1'b1, 1'b0, 1'b0);
            end
        end

        // Back-to-back changes: short pulse in the first yellow cycle (R6).
        do_reset();
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);

        // Pseudo-random walk against the model.
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[3], lfsr[7] & lfsr[9]);
        end

        // Reset from the farm green phase (R1).
        do_reset();
        go_to(2);
        do_reset();
        step(1'b0, 1'b0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule